// File: doc/BRIEF.md
# Continuation Token Routing Fabric

This block moves thread continuation tokens between fixed-latency function pipelines in a dataflow accelerator. A token holds everything a thread is: a target function code and two 32-bit argument words, a step counter `t` and a state word `s`. There is no call stack and no return path. A thread's next action is always the token it emits. Tokens that are waiting for the stepping function sit in a shared queue. A round-robin dispatcher hands each one to whichever replica of the stepping pipeline has room. Every replica output comes back to a round-robin merge, where it competes with fresh thread launches. The merge decodes the target code. A stepping token goes back into the queue. A terminating token leaves the fabric, and its state word is added into a running sum.

A run begins with a one-cycle `start_i` pulse that carries a thread count, a base seed and a step limit. The launcher acts as the zero-argument entry function and emits one opening token per thread. The number of live threads is capped, so the closed loop of queue, pipelines and output buffers can never fill and jam. When every requested thread has been launched and the live count is back at zero, `done_o` rises. The stepping pipeline is a stand-in for a real kernel. It computes a mixing value from the token in its first stage, applies the add and the increment in its second stage, and then delays the result to a parameterised total depth.

Top module: `cont_router`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `live_o`, `acc_o` and `term_count_o` are all zero.
- R2: A `start_i` pulse while idle clears the sum and the termination count and sets `busy_o`. It then launches `thread_count_i` threads. Thread k (k = 0 .. count-1) starts with t = 1 and s = `seed_i` + k (mod 2^32).
- R3: Each pass through the stepping pipeline with t < `step_limit_i` gives t' = t + 1 and s' = s + (((s << 5) ^ (s >> 3)) ^ t), all in 32 bits. A pass with t >= the limit turns the thread into a terminating token that carries s unchanged.
- R4: Each terminating token adds its zero-extended 32-bit state to `acc_o` (ACC_W bits, wrapping) and increments `term_count_o` by one. The sum does not depend on the order in which threads finish.
- R5: Once all threads have been launched and `live_o` is zero, `done_o` goes high and `busy_o` goes low. `done_o` stays high until the next accepted start, then drops one cycle after it.
- R6: A `start_i` pulse while `busy_o` is high is ignored. It changes neither the running job's parameters nor its results.
- R7: `live_o` never exceeds queue depth + replicas × output-buffer depth − 1 (11 with default parameters). No token is lost or duplicated, so `term_count_o` ends equal to the thread count.
- R8: A thread count of zero completes with a sum of zero. A step limit of 0 or 1 terminates each thread on its first pass, with no add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that starts a job |
| thread_count_i | input | CNT_W | Number of threads to launch |
| seed_i | input | 32 | Base state of thread 0 |
| step_limit_i | input | 32 | Counter value at which a thread terminates |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | Last job finished |
| live_o | output | LIVE_W | Threads launched and not yet terminated |
| acc_o | output | ACC_W | Sum of terminated thread states |
| term_count_o | output | CNT_W | Number of terminated threads |

## Verification
A token that is dropped, duplicated or routed to the wrong place shows up as a final `term_count_o` that differs from the thread count. It can also show up as `done_o` never rising, because `live_o` stays above zero. A corrupted argument field or a wrong pipeline stage changes `acc_o`, which is visible the moment the job ends. The sum over the threads differs from a per-thread sequential replay of the recurrence. A broken admission limit shows up within a few cycles of a large launch, either as `live_o` rising past its bound or as the loop jamming.

// File: rtl/cr_pkg.sv
package cr_pkg;
   localparam int ARG_W = 32;

   typedef enum logic [1:0] {
      TGT_ENTRY = 2'd0,
      TGT_STEP  = 2'd1,
      TGT_TERM  = 2'd2,
      TGT_SPARE = 2'd3
   } tgt_e;

   typedef struct packed {
      tgt_e             tgt;
      logic [ARG_W-1:0] t;
      logic [ARG_W-1:0] s;
   } token_t;

   localparam int TOK_W = $bits(token_t);

   // pseudo-random increment of the stand-in kernel
   function automatic logic [ARG_W-1:0] mix(input logic [ARG_W-1:0] s,
                                            input logic [ARG_W-1:0] t);
      return ((s << 5) ^ (s >> 3)) ^ t;
   endfunction
endpackage

// File: rtl/cr_fifo.sv
module cr_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] count
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("cr_fifo DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_q, rd_q;
   logic [CW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign count   = cnt_q;
   assign dout    = mem[rd_q];
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_q] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= wr_q + AW'(1);
         if (do_pop)  rd_q <= rd_q + AW'(1);
         cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
      end
   end

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && full));
   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop && empty));
endmodule

// File: rtl/cr_rr_arb.sv
module cr_rr_arb #(
   parameter int N = 2,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         any
);
   logic [IW-1:0] last_q, gidx;

   always_comb begin
      gnt  = '0;
      any  = 1'b0;
      gidx = last_q;
      for (int i = 1; i <= N; i++) begin
         int idx;
         idx = (int'(last_q) + i) % N;
         if (!any && req[idx]) begin
            gnt[idx] = 1'b1;
            any      = 1'b1;
            gidx     = IW'(idx);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   last_q <= IW'(N - 1);
      else if (any) last_q <= gidx;
   end

   assert_grant_requested_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
   assert_grant_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt) && (any == (req != '0)));
endmodule

// File: rtl/cr_step_pipe.sv
module cr_step_pipe
   import cr_pkg::*;
#(
   parameter int LAT   = 4,
   localparam int OCC_W = $clog2(LAT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  token_t           in_tok,
   input  logic [ARG_W-1:0] limit,
   output logic             out_valid,
   output token_t           out_tok,
   output logic [OCC_W-1:0] occ
);
   generate
      if (LAT < 2) begin : g_bad_lat
         $error("cr_step_pipe LAT must be at least 2");
      end
   endgenerate

   // stage 1: capture token, draw the random increment
   logic             v1_q;
   token_t           tok1_q;
   logic [ARG_W-1:0] rnd1_q;
   // stage 2: add and increment, decide the next target
   logic             v2_q;
   token_t           tok2_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1_q <= 1'b0;
         v2_q <= 1'b0;
      end else begin
         v1_q <= in_valid;
         v2_q <= v1_q;
      end
   end

   always_ff @(posedge clk) begin
      tok1_q <= in_tok;
      rnd1_q <= mix(in_tok.s, in_tok.t);
      if (tok1_q.t >= limit) begin
         tok2_q.tgt <= TGT_TERM;
         tok2_q.t   <= tok1_q.t;
         tok2_q.s   <= tok1_q.s;
      end else begin
         tok2_q.tgt <= TGT_STEP;
         tok2_q.t   <= tok1_q.t + ARG_W'(1);
         tok2_q.s   <= tok1_q.s + rnd1_q;
      end
   end

   generate
      if (LAT == 2) begin : g_direct
         assign out_valid = v2_q;
         assign out_tok   = tok2_q;
         assign occ       = OCC_W'(v1_q) + OCC_W'(v2_q);
      end else begin : g_delay
         localparam int ND = LAT - 2;
         logic   dv_q   [ND];
         token_t dtok_q [ND];
         logic [OCC_W-1:0] dcnt;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int k = 0; k < ND; k++) dv_q[k] <= 1'b0;
            end else begin
               dv_q[0] <= v2_q;
               for (int k = 1; k < ND; k++) dv_q[k] <= dv_q[k-1];
            end
         end

         always_ff @(posedge clk) begin
            dtok_q[0] <= tok2_q;
            for (int k = 1; k < ND; k++) dtok_q[k] <= dtok_q[k-1];
         end

         always_comb begin
            dcnt = OCC_W'(v1_q) + OCC_W'(v2_q);
            for (int k = 0; k < ND; k++) dcnt = dcnt + OCC_W'(dv_q[k]);
         end

         assign out_valid = dv_q[ND-1];
         assign out_tok   = dtok_q[ND-1];
         assign occ       = dcnt;
      end
   endgenerate

   assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_tok.tgt == TGT_STEP) |-> (out_tok.t <= limit && out_tok.t >= ARG_W'(2)));
endmodule

// File: rtl/cont_router.sv
module cont_router
   import cr_pkg::*;
#(
   parameter int N_REPL    = 2,
   parameter int Q_DEPTH   = 4,
   parameter int OUT_DEPTH = 4,
   parameter int PIPE_LAT  = 4,
   parameter int CNT_W     = 16,
   parameter int ACC_W     = 48,
   localparam int MAX_LIVE = Q_DEPTH + N_REPL * OUT_DEPTH - 1,
   localparam int LIVE_W   = $clog2(MAX_LIVE + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  thread_count_i,
   input  logic [ARG_W-1:0]  seed_i,
   input  logic [ARG_W-1:0]  step_limit_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [LIVE_W-1:0] live_o,
   output logic [ACC_W-1:0]  acc_o,
   output logic [CNT_W-1:0]  term_count_o
);
   localparam int NS    = N_REPL + 1;
   localparam int OCC_W = $clog2(PIPE_LAT + 1);
   localparam int OCW   = $clog2(OUT_DEPTH + 1);
   localparam int QCW   = $clog2(Q_DEPTH + 1);

   generate
      if (N_REPL < 1) begin : g_bad_repl
         $error("cont_router needs at least one replica");
      end
      if (ACC_W < ARG_W) begin : g_bad_acc
         $error("cont_router ACC_W must hold a full state word");
      end
   endgenerate

   // ---------------- job control and entry function ----------------
   logic              running_q, done_q;
   logic [CNT_W-1:0]  total_q, launched_q, term_q;
   logic [ARG_W-1:0]  seed_q, limit_q;
   logic [LIVE_W-1:0] live_q;
   logic [ACC_W-1:0]  acc_q;
   logic              launch_valid, launch_fire, term_fire, finish;
   token_t            launch_tok;

   assign launch_valid   = running_q && (launched_q < total_q) && (live_q < LIVE_W'(MAX_LIVE));
   assign launch_tok.tgt = TGT_STEP;
   assign launch_tok.t   = ARG_W'(1);
   assign launch_tok.s   = seed_q + ARG_W'(launched_q);
   assign finish         = running_q && (launched_q == total_q) && (live_q == '0);

   // ---------------- merge of launches and replica outputs ----------------
   logic   [NS-1:0] src_valid, src_req, mgnt;
   token_t          src_tok [NS];
   token_t          win;
   logic            m_any;
   logic            sq_full, sq_empty, sq_push;
   logic [TOK_W-1:0] sq_dout;
   logic [QCW-1:0]  sq_count;

   assign src_valid[0] = launch_valid;
   assign src_tok[0]   = launch_tok;

   always_comb begin
      for (int i = 0; i < NS; i++)
         src_req[i] = src_valid[i] && ((src_tok[i].tgt == TGT_STEP) ? !sq_full : 1'b1);
   end

   cr_rr_arb #(.N(NS)) u_merge (
      .clk(clk), .rst_n(rst_n), .req(src_req), .gnt(mgnt), .any(m_any)
   );

   always_comb begin
      win = '0;
      for (int i = 0; i < NS; i++)
         if (mgnt[i]) win = src_tok[i];
   end

   assign launch_fire = mgnt[0];
   assign sq_push     = m_any && (win.tgt == TGT_STEP);
   assign term_fire   = m_any && (win.tgt != TGT_STEP);

   // ---------------- stepping-function queue and dispatch ----------------
   logic [N_REPL-1:0] rdy, dreq, dgnt;
   logic              d_any;

   cr_fifo #(.W(TOK_W), .DEPTH(Q_DEPTH)) u_stepq (
      .clk(clk), .rst_n(rst_n), .push(sq_push), .din(win), .pop(d_any),
      .dout(sq_dout), .full(sq_full), .empty(sq_empty), .count(sq_count)
   );

   assign dreq = {N_REPL{!sq_empty}} & rdy;

   cr_rr_arb #(.N(N_REPL)) u_dispatch (
      .clk(clk), .rst_n(rst_n), .req(dreq), .gnt(dgnt), .any(d_any)
   );

   // ---------------- replicas with credit-guarded output buffers ----------------
   generate
      for (genvar r = 0; r < N_REPL; r++) begin : g_repl
         logic             p_valid;
         token_t           p_tok;
         logic [OCC_W-1:0] p_occ;
         logic [OCW-1:0]   o_cnt;
         logic             o_full, o_empty;
         logic [TOK_W-1:0] o_dout;

         cr_step_pipe #(.LAT(PIPE_LAT)) u_pipe (
            .clk(clk), .rst_n(rst_n), .in_valid(dgnt[r]), .in_tok(token_t'(sq_dout)),
            .limit(limit_q), .out_valid(p_valid), .out_tok(p_tok), .occ(p_occ)
         );

         cr_fifo #(.W(TOK_W), .DEPTH(OUT_DEPTH)) u_outq (
            .clk(clk), .rst_n(rst_n), .push(p_valid), .din(p_tok), .pop(mgnt[r+1]),
            .dout(o_dout), .full(o_full), .empty(o_empty), .count(o_cnt)
         );

         assign rdy[r]         = (int'(p_occ) + int'(o_cnt)) < OUT_DEPTH;
         assign src_valid[r+1] = !o_empty;
         assign src_tok[r+1]   = token_t'(o_dout);

         assert_credit_R7: assert property (@(posedge clk) disable iff (!rst_n)
            o_full |-> !p_valid);
      end
   endgenerate

   // ---------------- job state, live count, accumulator ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running_q  <= 1'b0;
         done_q     <= 1'b0;
         total_q    <= '0;
         launched_q <= '0;
         seed_q     <= '0;
         limit_q    <= '0;
         live_q     <= '0;
         acc_q      <= '0;
         term_q     <= '0;
      end else begin
         if (!running_q && start_i) begin
            running_q  <= 1'b1;
            done_q     <= 1'b0;
            total_q    <= thread_count_i;
            launched_q <= '0;
            seed_q     <= seed_i;
            limit_q    <= step_limit_i;
            acc_q      <= '0;
            term_q     <= '0;
         end else begin
            if (finish) begin
               running_q <= 1'b0;
               done_q    <= 1'b1;
            end
            if (launch_fire) launched_q <= launched_q + CNT_W'(1);
            if (term_fire) begin
               acc_q  <= acc_q + ACC_W'(win.s);
               term_q <= term_q + CNT_W'(1);
            end
         end
         live_q <= live_q + LIVE_W'(launch_fire) - LIVE_W'(term_fire);
      end
   end

   assign busy_o       = running_q;
   assign done_o       = done_q;
   assign live_o       = live_q;
   assign acc_o        = acc_q;
   assign term_count_o = term_q;

   assert_live_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      live_q <= LIVE_W'(MAX_LIVE));
   assert_term_has_thread_R4: assert property (@(posedge clk) disable iff (!rst_n)
      term_fire |-> (live_q != '0));
   assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && live_o == '0));
   assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !finish) |=> (busy_o && $stable(limit_q) && $stable(seed_q)));
   assert_idle_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (sq_count == '0));
endmodule

// File: tb/tb_cont_router.sv
module tb_cont_router;
   localparam int CNT_W    = 16;
   localparam int ACC_W    = 48;
   localparam int MAX_LIVE = 4 + 2 * 4 - 1;
   localparam int LIVE_W   = $clog2(MAX_LIVE + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [CNT_W-1:0]  thread_count_i = '0;
   logic [31:0]       seed_i = '0;
   logic [31:0]       step_limit_i = '0;
   logic              busy_o, done_o;
   logic [LIVE_W-1:0] live_o;
   logic [ACC_W-1:0]  acc_o;
   logic [CNT_W-1:0]  term_count_o;

   int checks = 0;
   int errors = 0;
   int max_live = 0;
   bit hung = 1'b0;

   always #4 clk = ~clk;

   cont_router dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .thread_count_i(thread_count_i),
      .seed_i(seed_i), .step_limit_i(step_limit_i), .busy_o(busy_o), .done_o(done_o),
      .live_o(live_o), .acc_o(acc_o), .term_count_o(term_count_o)
   );

   always @(negedge clk) if (rst_n && int'(live_o) > max_live) max_live = int'(live_o);

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // sequential per-thread replay of the recurrence (R2, R3, R4)
   function automatic logic [ACC_W-1:0] model_sum(input int n, input logic [31:0] seed,
                                                  input logic [31:0] lim);
      logic [ACC_W-1:0] sum = '0;
      for (int k = 0; k < n; k++) begin
         logic [31:0] s;
         logic [31:0] t;
         s = seed + 32'(k);
         t = 32'd1;
         while (t < lim) begin
            s = s + (((s << 5) ^ (s >> 3)) ^ t);
            t = t + 32'd1;
         end
         sum = sum + ACC_W'(s);
      end
      return sum;
   endfunction

   task automatic pulse_start(input int n, input logic [31:0] seed, input logic [31:0] lim);
      @(negedge clk);
      thread_count_i = CNT_W'(n);
      seed_i         = seed;
      step_limit_i   = lim;
      start_i        = 1'b1;
      @(negedge clk);
      start_i        = 1'b0;
   endtask

   task automatic wait_done(output bit ok);
      ok = 1'b0;
      for (int c = 0; c < 20000; c++) begin
         @(negedge clk);
         if (done_o) begin ok = 1'b1; break; end
      end
   endtask

   task automatic run_case(input int n, input logic [31:0] seed, input logic [31:0] lim);
      bit ok;
      logic [ACC_W-1:0] exp_sum;
      pulse_start(n, seed, lim);
      chk(busy_o && !done_o, "R5 busy after start", 64'(busy_o), 64'd1);
      wait_done(ok);
      chk(ok, "R5 done reached", 64'(ok), 64'd1);
      exp_sum = model_sum(n, seed, lim);
      chk(acc_o == exp_sum, (lim <= 1) ? "R8 sum" : "R3 R4 sum", 64'(acc_o), 64'(exp_sum));
      chk(int'(term_count_o) == n, (n == 0) ? "R8 count" : "R4 R7 count",
          64'(term_count_o), 64'(n));
      chk(!busy_o && live_o == '0, "R5 idle at done", 64'(live_o), 64'd0);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      hung = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [31:0] lims [5];
      logic [31:0] seeds [3];
      logic [ACC_W-1:0] exp_sum;
      bit ok;
      lims[0] = 32'd0; lims[1] = 32'd1; lims[2] = 32'd2; lims[3] = 32'd3; lims[4] = 32'd7;
      seeds[0] = 32'd0; seeds[1] = 32'hFFFF_FFFD; seeds[2] = 32'h1234_5678;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy_o && !done_o, "R1 flags", 64'({busy_o, done_o}), 64'd0);
      chk(live_o == '0 && term_count_o == '0, "R1 counts", 64'(term_count_o), 64'd0);
      chk(acc_o == '0, "R1 sum", 64'(acc_o), 64'd0);

      // R2 R3 R4 R8 sweep over counts, limits and seeds
      for (int n = 0; n <= 5; n++)
         for (int li = 0; li < 5; li++)
            for (int si = 0; si < 3; si++)
               run_case(n, seeds[si], lims[li]);

      // R5 done holds while idle, then drops one cycle after a start
      repeat (10) @(negedge clk);
      chk(done_o && !busy_o, "R5 done held", 64'(done_o), 64'd1);
      pulse_start(3, 32'd77, 32'd4);
      chk(!done_o, "R5 done cleared", 64'(done_o), 64'd0);
      chk(acc_o == '0 && term_count_o == '0, "R2 cleared on start", 64'(acc_o), 64'd0);
      wait_done(ok);
      exp_sum = model_sum(3, 32'd77, 32'd4);
      chk(ok && acc_o == exp_sum, "R4 sum after restart", 64'(acc_o), 64'(exp_sum));

      // R6 a start while busy is ignored
      pulse_start(8, 32'h0000_0100, 32'd12);
      repeat (5) @(negedge clk);
      pulse_start(2, 32'hDEAD_0000, 32'd3);
      chk(busy_o, "R6 still busy", 64'(busy_o), 64'd1);
      wait_done(ok);
      exp_sum = model_sum(8, 32'h0000_0100, 32'd12);
      chk(ok && acc_o == exp_sum, "R6 sum unchanged", 64'(acc_o), 64'(exp_sum));
      chk(term_count_o == CNT_W'(8), "R6 count unchanged", 64'(term_count_o), 64'd8);

      // R7 heavy load: admission cap and no token loss
      max_live = 0;
      run_case(40, 32'hCAFE_0001, 32'd25);
      chk(max_live <= MAX_LIVE, "R7 live bound", 64'(max_live), 64'(MAX_LIVE));
      chk(max_live == MAX_LIVE, "R7 cap reached", 64'(max_live), 64'(MAX_LIVE));

      if (!hung) begin
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule